// File: doc/BRIEF.md
# Profile-Switched DDS Phase Core

This block is the phase engine of a direct digital synthesizer that keeps four complete frequency/phase settings on chip and lets external hardware pick among them with a two-bit select value. Each setting holds a 32-bit frequency tuning word and a 14-bit phase offset. A phase accumulator advances by the chosen tuning word on every core clock. The chosen offset is added to the upper accumulator bits to form the output phase. The upper bits of that phase address a downstream 10-bit amplitude converter.

Software loads the settings through a small write port. Hardware then switches between them at high speed, with no register rewrites. For example, it can step the carrier by quarter turns for phase modulation. The select value is not taken on every core clock. It is captured once per synchronization tick, and a free-running divider raises that tick once every eight core clocks. All logic runs on the single core clock.

Top module: `dds_profile_core`

## Requirements
- R1: A synchronous active-high reset sets the accumulator and every stored tuning word and offset to zero, and sets the active setting to 0. The divider also restarts, so `phaseWord`, `lutAddr` and `activeProf` all read 0 after reset.
- R2: After reset, the divider raises a synchronization tick on every eighth core clock edge, starting with the eighth. The select input is captured only on a tick edge. A change on `profSel` between ticks leaves `activeProf` and the datapath unchanged.
- R3: On each core clock edge out of reset, the 32-bit accumulator adds the tuning word of the setting that is active before that edge. The sum wraps modulo 2^32.
- R4: `phaseWord` equals the top 14 bits of the accumulator plus the 14-bit offset of the active setting, modulo 2^14.
- R5: `lutAddr` equals the top 10 bits of `phaseWord`.
- R6: A write with `wrEn`=1 stores data in the setting given by `wrProf`. When `wrField`=0, all 32 bits of `wrData` go to the tuning word. When `wrField`=1, bits 13:0 of `wrData` go to the offset. The stored value is in place after that edge, and it affects the outputs only while that setting is active.
- R7: A captured select value n (binary, bit 1 high) makes setting n active, for n from 0 to 3.
- R8: With a zero tuning word and offsets 0x0000, 0x1000, 0x2000 and 0x3000 in settings 0 to 3, selecting setting n gives `phaseWord` = n*0x1000. This is quarter-turn phase modulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| profSel | input | 2 | Select of the setting to use, captured on synchronization ticks |
| wrEn | input | 1 | Write strobe for the setting store |
| wrProf | input | 2 | Setting index of the write |
| wrField | input | 1 | 0 writes the tuning word, 1 writes the phase offset |
| wrData | input | 32 | Write data; the offset uses bits 13:0 |
| phaseWord | output | 14 | Offset-adjusted output phase |
| lutAddr | output | 10 | Amplitude lookup address, top bits of the phase |
| activeProf | output | 2 | Setting currently driving the datapath |

## Verification
The hardest case to reach from the ports is a select change that lands between synchronization ticks while writes target a setting that is not active. In that case the outputs must stay tied to the old setting for up to seven more cycles. The bench tracks the divider phase in its own model. It waits for the cycle just after a tick, changes the select there, and checks that nothing moves until the next tick. Random traffic then mixes writes to active and idle settings with select changes at every divider phase. This covers accumulator wrap and offset wrap at the 14-bit boundary.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int FTW_W = 32;
  localparam int POW_W = 14;
  localparam int SEL_W = 2;
  localparam int NPROF = 1 << SEL_W;

  typedef struct packed {
    logic [NPROF-1:0] wrFreq;
    logic [NPROF-1:0] wrPhase;
    logic [FTW_W-1:0] wrData;
    logic [SEL_W-1:0] activeSel;
    logic             syncTick;
  } ctrlStrobe_t;
endpackage

// File: rtl/profile_ctrl.sv
module profile_ctrl
  import dds_pkg::*;
#(
  parameter int SYNC_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] profSel,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrProf,
  input  logic             wrField,
  input  logic [FTW_W-1:0] wrData,
  output ctrlStrobe_t      strb
);
  localparam int CNT_W = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic             syncTick;
  logic [SEL_W-1:0] selReg;

  // free-running divider; tick on its last count
  always_ff @(posedge clk) begin
    if (rst) divCnt <= '0;
    else if (divCnt == CNT_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign syncTick = (divCnt == CNT_LAST);

  // select captured only on synchronization ticks
  always_ff @(posedge clk) begin
    if (rst) selReg <= '0;
    else if (syncTick) selReg <= profSel;
  end

  // per-profile write decode
  for (genvar g = 0; g < NPROF; g++) begin : g_dec
    always_comb begin
      strb.wrFreq[g]  = wrEn && (wrProf == SEL_W'(g)) && !wrField;
      strb.wrPhase[g] = wrEn && (wrProf == SEL_W'(g)) && wrField;
    end
  end

  assign strb.wrData    = wrData;
  assign strb.activeSel = selReg;
  assign strb.syncTick  = syncTick;

  // R2: select stays put between ticks
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !syncTick |=> $stable(selReg));

  // R7: captured value equals the input seen at the tick
  p_sel_capture_r7: assert property (@(posedge clk) disable iff (rst)
    syncTick |=> (selReg == $past(profSel)));

  // R2: ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    syncTick |=> !syncTick);

  // R6: at most one field strobe per write
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({strb.wrFreq, strb.wrPhase}) <= 1);
endmodule

// File: rtl/phase_datapath.sv
module phase_datapath
  import dds_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strb,
  output logic [POW_W-1:0]  phaseWord,
  output logic [ADDR_W-1:0] lutAddr
);
  logic [FTW_W-1:0] ftwReg [NPROF];
  logic [POW_W-1:0] powReg [NPROF];
  logic [FTW_W-1:0] acc;
  logic [FTW_W-1:0] curFtw;
  logic [POW_W-1:0] curPow;

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    always_ff @(posedge clk) begin
      if (rst) begin
        ftwReg[g] <= '0;
        powReg[g] <= '0;
      end else begin
        if (strb.wrFreq[g])  ftwReg[g] <= strb.wrData;
        if (strb.wrPhase[g]) powReg[g] <= strb.wrData[POW_W-1:0];
      end
    end

    // R6: write lands in its own profile
    p_ftw_write_r6: assert property (@(posedge clk) disable iff (rst)
      strb.wrFreq[g] |=> (ftwReg[g] == $past(strb.wrData)));
    p_pow_write_r6: assert property (@(posedge clk) disable iff (rst)
      strb.wrPhase[g] |=> (powReg[g] == $past(strb.wrData[POW_W-1:0])));
  end

  always_comb begin
    curFtw = ftwReg[strb.activeSel];
    curPow = powReg[strb.activeSel];
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else acc <= acc + curFtw;
  end

  assign phaseWord = acc[FTW_W-1 -: POW_W] + curPow;
  assign lutAddr   = phaseWord[POW_W-1 -: ADDR_W];

  // R3: accumulator advances by the tuning word in use one cycle earlier
  p_acc_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (acc == $past(acc) + $past(curFtw)));
endmodule

// File: rtl/dds_profile_core.sv
module dds_profile_core
  import dds_pkg::*;
#(
  parameter int SYNC_DIV = 8,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        profSel,
  input  logic              wrEn,
  input  logic [1:0]        wrProf,
  input  logic              wrField,
  input  logic [31:0]       wrData,
  output logic [13:0]       phaseWord,
  output logic [ADDR_W-1:0] lutAddr,
  output logic [1:0]        activeProf
);
  ctrlStrobe_t strb;

  profile_ctrl #(.SYNC_DIV(SYNC_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .profSel(profSel), .wrEn(wrEn),
    .wrProf(wrProf), .wrField(wrField), .wrData(wrData), .strb(strb)
  );

  phase_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .phaseWord(phaseWord), .lutAddr(lutAddr)
  );

  assign activeProf = strb.activeSel;
endmodule

// File: tb/tb_dds_profile_core.sv
module tb_dds_profile_core;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] profSel;
  logic wrEn;
  logic [1:0] wrProf;
  logic wrField;
  logic [31:0] wrData;
  logic [13:0] phaseWord;
  logic [9:0] lutAddr;
  logic [1:0] activeProf;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mFtw [4];
  logic [13:0] mPow [4];
  logic [31:0] mAcc;
  logic [1:0]  mSel;
  int          mCnt;

  always #2 clk = ~clk;

  dds_profile_core dut (
    .clk(clk), .rst(rst), .profSel(profSel), .wrEn(wrEn), .wrProf(wrProf),
    .wrField(wrField), .wrData(wrData), .phaseWord(phaseWord),
    .lutAddr(lutAddr), .activeProf(activeProf)
  );

  function automatic logic [13:0] expPhase();
    return 14'(mAcc[31:18] + mPow[mSel]);
  endfunction

  task automatic modelEdge();
    logic [31:0] nAcc;
    logic [1:0]  nSel;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin mFtw[i] = '0; mPow[i] = '0; end
      mAcc = '0; mSel = '0; mCnt = 0;
    end else begin
      nAcc = mAcc + mFtw[mSel];
      nSel = (mCnt == 7) ? profSel : mSel;
      mCnt = (mCnt + 1) % 8;
      if (wrEn) begin
        if (wrField) mPow[wrProf] = wrData[13:0];
        else mFtw[wrProf] = wrData;
      end
      mAcc = nAcc;
      mSel = nSel;
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkAll(string tag);
    chk({tag, "/R4 phase"}, int'(phaseWord), int'(expPhase()));
    chk("R5 lutAddr", int'(lutAddr), int'(expPhase() >> 4));
    chk("R2 activeProf", int'(activeProf), int'(mSel));
  endtask

  task automatic wr(logic [1:0] p, logic f, logic [31:0] d);
    wrEn = 1'b1; wrProf = p; wrField = f; wrData = d;
    step();
    wrEn = 1'b0;
    chkAll("R6");
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4242);
    rst = 1'b1; profSel = '0; wrEn = 1'b0; wrProf = '0; wrField = 1'b0; wrData = '0;
    step(); step();
    rst = 1'b0;
    // R1: reset state
    chk("R1 phase", int'(phaseWord), 0);
    chk("R1 lutAddr", int'(lutAddr), 0);
    chk("R1 activeProf", int'(activeProf), 0);

    // R8: quarter-turn offsets, zero tuning word
    wr(2'd0, 1'b1, 32'h0000);
    wr(2'd1, 1'b1, 32'h1000);
    wr(2'd2, 1'b1, 32'h2000);
    wr(2'd3, 1'b1, 32'h3000);
    for (int s = 0; s < 4; s++) begin
      profSel = 2'(s);
      for (int k = 0; k < 8; k++) step();
      chk("R7 select maps to profile", int'(activeProf), s);
      chk("R8 quadrature phase", int'(phaseWord), s * 32'h1000);
      chkAll("R8");
    end

    // R2: change select right after a tick; no effect until next tick
    while (mCnt != 0) step();
    begin
      logic [1:0] oldSel;
      oldSel = activeProf;
      profSel = oldSel + 2'd1;
      for (int k = 0; k < 7; k++) begin
        step();
        chk("R2 held between ticks", int'(activeProf), int'(oldSel));
        chkAll("R2");
      end
      step();
      chk("R2 taken at tick", int'(activeProf), int'(2'(oldSel + 2'd1)));
    end

    // R3: wrap of accumulator with half-turn tuning word
    wr(activeProf, 1'b0, 32'h8000_0000);
    wr(activeProf, 1'b1, 32'h3FFF);
    for (int k = 0; k < 6; k++) begin step(); chkAll("R3"); end
    wr(activeProf, 1'b0, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin step(); chkAll("R3"); end

    // R6: writes to an idle profile do not disturb the output
    for (int k = 0; k < 8; k++) begin
      wr(activeProf + 2'd2, 1'(k), $urandom);
    end

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      wrEn = ($urandom % 4) == 0;
      wrProf = 2'($urandom);
      wrField = 1'($urandom);
      wrData = $urandom;
      if (($urandom % 5) == 0) profSel = 2'($urandom);
      step();
      chkAll("R6 random");
    end
    wrEn = 1'b0;

    // R1: reset mid-run clears everything
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 phase after reset", int'(phaseWord), 0);
    chk("R1 active after reset", int'(activeProf), 0);
    step();
    chk("R1 acc stays zero", int'(phaseWord), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule